// File: doc/BRIEF.md
# Vacuum Fluorescent Display Scanner with Key Matrix Scan

This block drives a time-multiplexed vacuum fluorescent display and reads a key matrix through the same lines. A frame is a run of display slots, one per grid timing, followed by a key-scan slot. The number of display slots per frame is set by a configuration input and may be anywhere from 1 to 20. Each display slot opens with a short blanking interval in which every output is off and the segment pattern of that timing is fetched from an external display memory. The lit part follows. A three-bit dimmer value limits the lit part to a number of eighths of the slot, and the outputs stay dark for the rest of the slot.

Sixteen dual-use output pins are set, pin by pin, to act either as grid drivers or as extra segment lines. A grid-mode pin is driven during the lit part of the timing whose index equals the pin number. A segment-mode pin shows a bit of the fetched word. In the key-scan slot the grids stay off and the low segment lines are raised one at a time. The eight key-return inputs are then sampled into a bank of sixteen key bytes, and an interrupt pulse is raised when any byte differs from the previous frame.

Sequencer states and transitions: `PH_BLANK` (outputs off, memory fetch in its first cycle) goes to `PH_LIT` at the end of blanking. `PH_LIT` goes to `PH_DARK` when the dimmed on-time runs out. `PH_LIT` or `PH_DARK` ends the slot at its last active cycle. The slot end goes to `PH_BLANK` of the next timing, or to `PH_KEYS` after the last timing. `PH_KEYS` returns to `PH_BLANK` of timing 0 after the last scan line. A restart from any state goes to `PH_BLANK` of timing 0.

Top module: `vfd_scan_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, grid_o, seg_o and key_irq are 0. All key bytes read 0. The first frame starts with blanking of timing 0.
- R2: A timing count of 0 is treated as 1, and a value above 20 is treated as 20. A frame has that many display slots, taken in timing order 0, 1, 2 and so on, followed by one key-scan slot.
- R3: A display slot begins with BLANK_CYC cycles in which grid_o and seg_o are all 0. dm_ren is 1 only in the first of these cycles, and dm_addr then carries the timing index. The read word is expected on dm_rdata one cycle later.
- R4: During the lit part of a slot, seg_o equals bits [SEG_W-1:0] of the word fetched for that timing.
- R5: During the lit part, a dual pin i with grid_mode[i]=1 is 1 exactly when the timing index equals i. A dual pin with grid_mode[i]=0 shows bit SEG_W+i of the fetched word.
- R6: At no time is more than one grid-mode pin driven.
- R7: The active part of a slot lasts 8*STEP_CYC cycles. It is lit for (dim_lvl+1)*STEP_CYC cycles, using the dim_lvl value present at the end of blanking, and dark with all outputs 0 for the remainder.
- R8: In the key-scan slot grid_o is 0. seg_o has only bit L set for scan line L. Lines 0 to 15 are driven in order, for KEY_CYC cycles each.
- R9: key_ret is sampled in the last cycle of each scan line and stored as key byte L. key_byte shows the byte selected by key_sel.
- R10: key_irq is a one-cycle pulse in the cycle after the last scan line's sample, raised only if some key byte changed value in that frame.
- R11: When the clamped timing count differs from the value in use, the next cycle is blanking of timing 0, with a fresh fetch for timing 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tim_cfg | input | TIM_W (5) | Requested number of grid timings per frame |
| dim_lvl | input | 3 | Dimmer, on-time in eighths of the active part minus one |
| grid_mode | input | GRID_W (16) | Per dual pin: 1 = grid, 0 = segment |
| dm_ren | output | 1 | Display memory read request |
| dm_addr | output | TIM_W (5) | Display memory address (timing index) |
| dm_rdata | input | GRID_W+SEG_W (40) | Display memory word, one cycle after the request |
| grid_o | output | GRID_W (16) | Dual-use grid/segment outputs |
| seg_o | output | SEG_W (24) | Segment outputs, also key scan lines |
| key_ret | input | KEY_W (8) | Key-return inputs |
| key_sel | input | LINE_W (4) | Key byte select |
| key_byte | output | KEY_W (8) | Selected key byte |
| key_irq | output | 1 | Key change pulse |

## Verification
The assertions assume three things about the inputs: dm_rdata holds the requested word exactly one edge after dm_ren, key_ret depends only on the scan line currently driven, and BLANK_CYC is at least 2, so the fetched word reaches the pattern register before the lit part starts. The bench models the memory as a register that loads on every request. It derives key_ret combinationally from seg_o and a key matrix variable. It changes tim_cfg, dim_lvl and grid_mode only at the start of a scenario, and it changes the key matrix only during display slots, so every captured key byte and every dimmer window is known in advance.

// File: rtl/vfd_pkg.sv
`timescale 1ns/1ps
package vfd_pkg;
    typedef enum logic [1:0] {
        PH_BLANK = 2'd0,
        PH_LIT   = 2'd1,
        PH_DARK  = 2'd2,
        PH_KEYS  = 2'd3
    } vfd_phase_e;
endpackage

// File: rtl/vfd_cfg.sv
`timescale 1ns/1ps
module vfd_cfg #(
    parameter int MAX_TIM = 20,
    parameter int TIM_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TIM_W-1:0] tim_cfg,
    output logic [TIM_W-1:0] tim_n,
    output logic             restart
);
    localparam logic [TIM_W-1:0] TOP = TIM_W'(MAX_TIM);

    logic [TIM_W-1:0] want;
    logic [TIM_W-1:0] tim_q;

    // clamp the request into 1..MAX_TIM
    always_comb begin
        if (tim_cfg == '0)
            want = TIM_W'(1);
        else if (tim_cfg > TOP)
            want = TOP;
        else
            want = tim_cfg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            tim_q <= TIM_W'(1);
        else
            tim_q <= want;
    end

    assign restart = (want != tim_q);
    assign tim_n   = tim_q;

    // R2: count in use always legal
    p_count_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tim_q != '0) && (tim_q <= TOP));
endmodule

// File: rtl/vfd_seq.sv
`timescale 1ns/1ps
module vfd_seq #(
    parameter int BLANK_CYC = 2,
    parameter int STEP_CYC  = 2,
    parameter int KEY_CYC   = 2,
    parameter int KEY_LINES = 16,
    parameter int TIM_W     = 5,
    parameter int LINE_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic [TIM_W-1:0]     tim_n,
    input  logic [2:0]           dim_lvl,
    output vfd_pkg::vfd_phase_e  phase,
    output logic [TIM_W-1:0]     tim_idx,
    output logic [LINE_W-1:0]    line_idx,
    output logic                 fetch,
    output logic                 sample,
    output logic                 frame_end
);
    import vfd_pkg::*;

    localparam int ACT_CYC = 8 * STEP_CYC;
    localparam int MAX_A   = (ACT_CYC > BLANK_CYC) ? ACT_CYC : BLANK_CYC;
    localparam int MAX_C   = (MAX_A > KEY_CYC) ? MAX_A : KEY_CYC;
    localparam int CNT_W   = $clog2(MAX_C + 1);

    localparam logic [CNT_W-1:0]  BLANK_LAST = CNT_W'(BLANK_CYC - 1);
    localparam logic [CNT_W-1:0]  ACT_LAST   = CNT_W'(ACT_CYC - 1);
    localparam logic [CNT_W-1:0]  KEY_LAST   = CNT_W'(KEY_CYC - 1);
    localparam logic [CNT_W-1:0]  ACT_LEN    = CNT_W'(ACT_CYC);
    localparam logic [LINE_W-1:0] LINE_LAST  = LINE_W'(KEY_LINES - 1);

    vfd_phase_e        phase_q, phase_d;
    logic [TIM_W-1:0]  tim_q, tim_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [CNT_W-1:0]  onl_q, onl_d;
    logic              slot_done;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_BLANK;
            tim_q   <= '0;
            line_q  <= '0;
            cnt_q   <= '0;
            onl_q   <= ACT_LEN;
        end else begin
            phase_q <= phase_d;
            tim_q   <= tim_d;
            line_q  <= line_d;
            cnt_q   <= cnt_d;
            onl_q   <= onl_d;
        end
    end

    // next state
    always_comb begin
        phase_d   = phase_q;
        tim_d     = tim_q;
        line_d    = line_q;
        cnt_d     = cnt_q;
        onl_d     = onl_q;
        slot_done = 1'b0;
        unique case (phase_q)
            PH_BLANK: begin
                if (cnt_q == BLANK_LAST) begin
                    phase_d = PH_LIT;
                    cnt_d   = '0;
                    onl_d   = CNT_W'((int'(dim_lvl) + 1) * STEP_CYC);
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            PH_LIT: begin
                if (cnt_q == ACT_LAST) begin
                    slot_done = 1'b1;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                    if (cnt_q == onl_q - CNT_W'(1))
                        phase_d = PH_DARK;
                end
            end
            PH_DARK: begin
                if (cnt_q == ACT_LAST)
                    slot_done = 1'b1;
                else
                    cnt_d = cnt_q + CNT_W'(1);
            end
            PH_KEYS: begin
                if (cnt_q == KEY_LAST) begin
                    cnt_d = '0;
                    if (line_q == LINE_LAST) begin
                        phase_d = PH_BLANK;
                        tim_d   = '0;
                        line_d  = '0;
                    end else begin
                        line_d = line_q + LINE_W'(1);
                    end
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
        endcase
        if (slot_done) begin
            cnt_d = '0;
            if (tim_q == tim_n - TIM_W'(1)) begin
                phase_d = PH_KEYS;
                line_d  = '0;
            end else begin
                phase_d = PH_BLANK;
                tim_d   = tim_q + TIM_W'(1);
            end
        end
        if (restart) begin
            phase_d = PH_BLANK;
            tim_d   = '0;
            line_d  = '0;
            cnt_d   = '0;
        end
    end

    // outputs
    always_comb begin
        phase     = phase_q;
        tim_idx   = tim_q;
        line_idx  = line_q;
        fetch     = (phase_q == PH_BLANK) && (cnt_q == '0);
        sample    = (phase_q == PH_KEYS) && (cnt_q == KEY_LAST);
        frame_end = sample && (line_q == LINE_LAST);
    end

    // R7: lit part never runs past the dimmed on-time
    p_lit_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_LIT) |-> (cnt_q < onl_q));
    // R7: a dark part only exists when the on-time is shorter than the slot
    p_dark_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_DARK) |-> (onl_q < ACT_LEN));
    // R2: timing index stays below the count in use
    p_slot_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tim_q < tim_n);
    // R8: scan lines advance one at a time
    p_line_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_KEYS && cnt_q == KEY_LAST && line_q != LINE_LAST && !restart)
        |=> (line_q == $past(line_q) + LINE_W'(1)));
endmodule

// File: rtl/vfd_outmux.sv
`timescale 1ns/1ps
module vfd_outmux #(
    parameter int GRID_W    = 16,
    parameter int SEG_W     = 24,
    parameter int KEY_LINES = 16,
    parameter int TIM_W     = 5,
    parameter int LINE_W    = 4
) (
    input  vfd_pkg::vfd_phase_e      phase,
    input  logic [TIM_W-1:0]         tim_idx,
    input  logic [LINE_W-1:0]        line_idx,
    input  logic [GRID_W+SEG_W-1:0]  pat,
    input  logic [GRID_W-1:0]        grid_mode,
    output logic [GRID_W-1:0]        grid_o,
    output logic [SEG_W-1:0]         seg_o
);
    import vfd_pkg::*;

    logic [GRID_W-1:0] lit_grid;
    logic [SEG_W-1:0]  key_drive;

    for (genvar gi = 0; gi < GRID_W; gi++) begin : g_dual
        assign lit_grid[gi] = grid_mode[gi] ? (tim_idx == TIM_W'(gi))
                                            : pat[SEG_W + gi];
    end

    for (genvar ki = 0; ki < SEG_W; ki++) begin : g_scan
        if (ki < KEY_LINES) begin : g_line
            assign key_drive[ki] = (line_idx == LINE_W'(ki));
        end else begin : g_idle
            assign key_drive[ki] = 1'b0;
        end
    end

    always_comb begin
        unique case (phase)
            PH_LIT: begin
                grid_o = lit_grid;
                seg_o  = pat[SEG_W-1:0];
            end
            PH_KEYS: begin
                grid_o = '0;
                seg_o  = key_drive;
            end
            PH_BLANK, PH_DARK: begin
                grid_o = '0;
                seg_o  = '0;
            end
        endcase
    end
endmodule

// File: rtl/vfd_keybank.sv
`timescale 1ns/1ps
module vfd_keybank #(
    parameter int KEY_LINES = 16,
    parameter int KEY_W     = 8,
    parameter int LINE_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              sample,
    input  logic              frame_end,
    input  logic [LINE_W-1:0] line_idx,
    input  logic [KEY_W-1:0]  key_ret,
    input  logic [LINE_W-1:0] key_sel,
    output logic [KEY_W-1:0]  key_byte,
    output logic              key_irq
);
    logic [KEY_W-1:0] bank [KEY_LINES];
    logic             acc_q;
    logic             irq_q;
    logic             diff_now;

    assign diff_now = (bank[line_idx] != key_ret);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < KEY_LINES; i++)
                bank[i] <= '0;
            acc_q <= 1'b0;
            irq_q <= 1'b0;
        end else begin
            if (sample)
                bank[line_idx] <= key_ret;
            if (restart || frame_end)
                acc_q <= 1'b0;
            else if (sample && diff_now)
                acc_q <= 1'b1;
            irq_q <= frame_end && !restart && (acc_q || diff_now);
        end
    end

    assign key_byte = bank[key_sel];
    assign key_irq  = irq_q;

    // R10: interrupt is a single-cycle pulse
    p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |=> !key_irq);
    // R10: interrupt only follows the end of a key scan
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |-> $past(frame_end));
endmodule

// File: rtl/vfd_scan_ctrl.sv
`timescale 1ns/1ps
module vfd_scan_ctrl #(
    parameter int GRID_W    = 16,
    parameter int SEG_W     = 24,
    parameter int MAX_TIM   = 20,
    parameter int BLANK_CYC = 2,
    parameter int STEP_CYC  = 2,
    parameter int KEY_CYC   = 2,
    parameter int KEY_LINES = 16,
    parameter int KEY_W     = 8,
    localparam int TIM_W    = $clog2(MAX_TIM + 1),
    localparam int LINE_W   = $clog2(KEY_LINES),
    localparam int PAT_W    = GRID_W + SEG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIM_W-1:0]  tim_cfg,
    input  logic [2:0]        dim_lvl,
    input  logic [GRID_W-1:0] grid_mode,
    output logic              dm_ren,
    output logic [TIM_W-1:0]  dm_addr,
    input  logic [PAT_W-1:0]  dm_rdata,
    output logic [GRID_W-1:0] grid_o,
    output logic [SEG_W-1:0]  seg_o,
    input  logic [KEY_W-1:0]  key_ret,
    input  logic [LINE_W-1:0] key_sel,
    output logic [KEY_W-1:0]  key_byte,
    output logic              key_irq
);
    import vfd_pkg::*;

    logic [TIM_W-1:0]  tim_n;
    logic              restart;
    vfd_phase_e        phase;
    logic [TIM_W-1:0]  tim_idx;
    logic [LINE_W-1:0] line_idx;
    logic              fetch, sample, frame_end;
    logic              fetch_d;
    logic [PAT_W-1:0]  pat_q;

    vfd_cfg #(.MAX_TIM(MAX_TIM), .TIM_W(TIM_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .tim_cfg(tim_cfg),
        .tim_n(tim_n), .restart(restart)
    );

    vfd_seq #(
        .BLANK_CYC(BLANK_CYC), .STEP_CYC(STEP_CYC), .KEY_CYC(KEY_CYC),
        .KEY_LINES(KEY_LINES), .TIM_W(TIM_W), .LINE_W(LINE_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .restart(restart), .tim_n(tim_n),
        .dim_lvl(dim_lvl), .phase(phase), .tim_idx(tim_idx),
        .line_idx(line_idx), .fetch(fetch), .sample(sample),
        .frame_end(frame_end)
    );

    // pattern register: word arrives one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_d <= 1'b0;
            pat_q   <= '0;
        end else begin
            fetch_d <= fetch;
            if (fetch_d)
                pat_q <= dm_rdata;
        end
    end

    assign dm_ren  = fetch;
    assign dm_addr = tim_idx;

    vfd_outmux #(
        .GRID_W(GRID_W), .SEG_W(SEG_W), .KEY_LINES(KEY_LINES),
        .TIM_W(TIM_W), .LINE_W(LINE_W)
    ) u_mux (
        .phase(phase), .tim_idx(tim_idx), .line_idx(line_idx),
        .pat(pat_q), .grid_mode(grid_mode),
        .grid_o(grid_o), .seg_o(seg_o)
    );

    vfd_keybank #(.KEY_LINES(KEY_LINES), .KEY_W(KEY_W), .LINE_W(LINE_W)) u_keys (
        .clk(clk), .rst_n(rst_n), .restart(restart), .sample(sample),
        .frame_end(frame_end), .line_idx(line_idx), .key_ret(key_ret),
        .key_sel(key_sel), .key_byte(key_byte), .key_irq(key_irq)
    );

    // R3: blanking and dimmed remainder keep every output off
    p_blank_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_BLANK || phase == PH_DARK) |-> (grid_o == '0 && seg_o == '0));
    // R6: never two grids at once
    p_grid_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grid_o & grid_mode));
    // R8: key slot drives exactly one scan line and no grid
    p_key_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_KEYS) |-> (grid_o == '0 && $countones(seg_o) == 1));
    // R11: count change restarts at blanking of timing 0
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase == PH_BLANK && tim_idx == '0 && dm_ren));
    // R1: outputs are off in the first cycle out of reset
    p_reset_off_r1: assert property (@(posedge clk)
        !rst_n |=> (grid_o == '0 && seg_o == '0 && !key_irq));
endmodule

// File: tb/tb_vfd_scan_ctrl.sv
`timescale 1ns/1ps
module tb_vfd_scan_ctrl;
    localparam int GRID_W = 16;
    localparam int SEG_W  = 24;
    localparam int TIM_W  = 5;
    localparam int LINE_W = 4;
    localparam int KEY_W  = 8;
    localparam int LINES  = 16;
    localparam int BLANK  = 2;
    localparam int STEP   = 2;
    localparam int KCYC   = 2;
    localparam int SLOT   = BLANK + 8 * STEP;
    localparam int PAT_W  = GRID_W + SEG_W;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [TIM_W-1:0]  tim_cfg;
    logic [2:0]        dim_lvl;
    logic [GRID_W-1:0] grid_mode;
    logic              dm_ren;
    logic [TIM_W-1:0]  dm_addr;
    logic [PAT_W-1:0]  dm_rdata;
    logic [GRID_W-1:0] grid_o;
    logic [SEG_W-1:0]  seg_o;
    logic [KEY_W-1:0]  key_ret;
    logic [LINE_W-1:0] key_sel;
    logic [KEY_W-1:0]  key_byte;
    logic              key_irq;

    logic [KEY_W-1:0]  keys_m [LINES];
    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    vfd_scan_ctrl dut (
        .clk(clk), .rst_n(rst_n), .tim_cfg(tim_cfg), .dim_lvl(dim_lvl),
        .grid_mode(grid_mode), .dm_ren(dm_ren), .dm_addr(dm_addr),
        .dm_rdata(dm_rdata), .grid_o(grid_o), .seg_o(seg_o),
        .key_ret(key_ret), .key_sel(key_sel), .key_byte(key_byte),
        .key_irq(key_irq)
    );

    function automatic logic [PAT_W-1:0] mem_word(input int t);
        logic [23:0] s;
        logic [15:0] d;
        s = 24'hA5_0000 ^ (24'(t) * 24'h01_0123);
        d = 16'hC3C3 ^ (16'(t) * 16'h0F11);
        return {d, s};
    endfunction

    // display memory: word ready one edge after the request
    always @(posedge clk) begin
        if (dm_ren)
            dm_rdata <= mem_word(int'(dm_addr));
    end

    // key matrix: returns follow the driven scan line
    always_comb begin
        key_ret = '0;
        for (int l = 0; l < LINES; l++)
            if (seg_o[l]) key_ret = key_ret | keys_m[l];
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic int clampn(input int r);
        if (r == 0) return 1;
        if (r > 20) return 20;
        return r;
    endfunction

    // compare one cycle c (1 = first cycle after restart) against the model
    task automatic check_cycle(input int c, input int n, input int dim,
                               input logic [GRID_W-1:0] gm);
        int f, p, slot, off;
        logic [GRID_W-1:0] eg;
        logic [SEG_W-1:0]  es;
        logic [PAT_W-1:0]  w;
        logic              eren;
        string             req;
        f = SLOT * n + LINES * KCYC;
        p = (c - 1) % f;
        eg = '0; es = '0; eren = 1'b0; slot = 0;
        if (p < SLOT * n) begin
            slot = p / SLOT;
            off  = p % SLOT;
            if (off < BLANK) begin
                req  = "R3";
                eren = (off == 0);
            end else if (off - BLANK < (dim + 1) * STEP) begin
                req = "R4/R5/R6";
                w  = mem_word(slot);
                es = w[SEG_W-1:0];
                for (int i = 0; i < GRID_W; i++)
                    eg[i] = gm[i] ? (slot == i) : w[SEG_W + i];
            end else begin
                req = "R7";
            end
        end else begin
            req = "R8";
            es  = SEG_W'(1) << ((p - SLOT * n) / KCYC);
        end
        check({grid_o, seg_o} == {eg, es}, req, $sformatf("outputs cycle %0d", c),
              64'({grid_o, seg_o}), 64'({eg, es}));
        check(dm_ren == eren, "R3", $sformatf("dm_ren cycle %0d", c),
              64'(dm_ren), 64'(eren));
        if (eren)
            check(dm_addr == TIM_W'(slot), "R3 R2", $sformatf("dm_addr cycle %0d", c),
                  64'(dm_addr), 64'(slot));
    endtask

    // change the count (restart) and follow a number of cycles with no keys
    task automatic run_frames(input int cfg, input int dim, input logic [GRID_W-1:0] gm,
                              input int ncyc, input string tag);
        int n;
        n = clampn(cfg);
        dim_lvl   = 3'(dim);
        grid_mode = gm;
        tim_cfg   = TIM_W'(cfg);
        tick();
        check(grid_o == '0 && seg_o == '0 && dm_ren && dm_addr == '0, "R11",
              {tag, " first cycle after count change"},
              64'({dm_ren, dm_addr, grid_o, seg_o}), 64'({1'b1, 5'd0, 40'd0}));
        for (int c = 1; c <= ncyc; c++) begin
            check_cycle(c, n, dim, gm);
            check(!key_irq, "R10", {tag, " no interrupt without key change"},
                  64'(key_irq), 64'd0);
            tick();
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tim_cfg = TIM_W'(1);
        dim_lvl = 3'd7;
        grid_mode = '1;
        key_sel = '0;
        for (int l = 0; l < LINES; l++) keys_m[l] = '0;
        repeat (3) tick();
        check(grid_o == '0 && seg_o == '0 && !key_irq, "R1", "outputs in reset",
              64'({key_irq, grid_o, seg_o}), 64'd0);
        for (int l = 0; l < LINES; l++) begin
            key_sel = LINE_W'(l);
            #0.1;
            check(key_byte == '0, "R1", $sformatf("key byte %0d after reset", l),
                  64'(key_byte), 64'd0);
        end
        rst_n = 1'b1;
        // first frame from reset: one timing, full brightness
        for (int c = 1; c <= 2 * (SLOT + LINES * KCYC); c++) begin
            check_cycle(c, 1, 7, '1);
            tick();
        end
    endtask

    task automatic t_three_full();
        run_frames(3, 7, 16'hFFFF, 2 * (3 * SLOT + LINES * KCYC), "three timings");
    endtask

    task automatic t_zero_count_dim();
        run_frames(0, 3, 16'h00FF, 2 * (SLOT + LINES * KCYC), "count 0 dim 3");
    endtask

    task automatic t_big_count_min_dim();
        run_frames(25, 0, 16'hFFFF, 20 * SLOT + LINES * KCYC, "count 25 dim 0");
    endtask

    task automatic t_mid_restart();
        run_frames(4, 5, 16'h5A5A, 30, "restart source");
        run_frames(2, 1, 16'h0F0F, 2 * SLOT + LINES * KCYC + 5, "restart mid lit");
    endtask

    task automatic t_keys();
        int n, f;
        logic [KEY_W-1:0] exp1 [LINES];
        n = 5;
        f = n * SLOT + LINES * KCYC;
        for (int l = 0; l < LINES; l++) begin
            keys_m[l] = (l == 3) ? 8'h00 : 8'(l * 37 + 5);
            exp1[l]   = keys_m[l];
        end
        dim_lvl = 3'd7;
        grid_mode = 16'hA5A5;
        tim_cfg = TIM_W'(n);
        tick();
        for (int c = 1; c <= 3 * f + LINES + 1; c++) begin
            bit want_irq;
            check_cycle(c, n, 7, 16'hA5A5);
            want_irq = (c == f + 1) || (c == 3 * f + 1);
            check(key_irq == want_irq, "R10", $sformatf("key_irq cycle %0d", c),
                  64'(key_irq), 64'(want_irq));
            if (c >= f + 1 && c < f + 1 + LINES) begin
                key_sel = LINE_W'(c - f - 1);
                #0.2;
                check(key_byte == exp1[c - f - 1], "R9",
                      $sformatf("frame 1 key byte %0d", c - f - 1),
                      64'(key_byte), 64'(exp1[c - f - 1]));
            end
            if (c == 2 * f + 2) begin
                keys_m[7] = keys_m[7] ^ 8'h10;
                exp1[7]   = keys_m[7];
            end
            if (c >= 3 * f + 1 && c < 3 * f + 1 + LINES) begin
                key_sel = LINE_W'(c - 3 * f - 1);
                #0.2;
                check(key_byte == exp1[c - 3 * f - 1], "R9",
                      $sformatf("frame 3 key byte %0d", c - 3 * f - 1),
                      64'(key_byte), 64'(exp1[c - 3 * f - 1]));
            end
            tick();
        end
    endtask

    initial begin
        t_reset();
        t_three_full();
        t_zero_count_dim();
        t_big_count_min_dim();
        t_mid_restart();
        t_keys();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule